// File: doc/BRIEF.md
# Eight-Channel Byte DMA Engine

This block copies bytes between a wide memory-side bus (16-bit address plus an 8-bit bank, 24 bits in all) and a narrow peripheral-side bus that has 8-bit addresses. Each of its eight channels keeps a small set of byte registers: a control byte, a peripheral base address, a 16-bit memory address with its bank, a 16-bit byte count and a few spare bytes. The CPU writes and reads these registers through a simple port. Reads of unmapped offsets return whatever value the system drives on `openBus`.

Software starts a burst by writing an enable mask, one bit per channel. The engine first waits through a startup overhead. It then serves the enabled channels one at a time, lowest number first, and runs each channel to completion before it moves to the next. It moves one byte per step. Every step spends a fixed number of cycles, and each completed channel adds an extra penalty. While the burst and its overhead are in progress, `busy` is held high so that the rest of the system can be stalled.

Top module: `dma_engine`

## Requirements
- R1: The register address is `{channel[2:0], offset[3:0]}`. Each channel's registers sit at these offsets: 0 control, 1 peripheral base, 2 memory address low, 3 memory address high, 4 memory bank, 5 count low, 6 count high, 7 indirect bank, 8 table address low, 9 table address high, 0xA line counter. Offsets 0xB and 0xF are both the same spare byte. A read of offsets 0xC, 0xD or 0xE returns `openBus`.
- R2: After reset, every channel register reads 0xFF, `busy` is low and no bus strobe is active.
- R3: In the control byte, bits 2:0 give the mode, bit 3 holds the memory address fixed, bit 4 makes it count down, and bit 7 sets the direction (1 means peripheral to memory). Bits 5 and 6 are stored and read back unchanged.
- R4: Each byte step asserts exactly one memory strobe and one peripheral strobe in the same cycle. With direction 0, `aRd` and `bWr` are high and `bWrData` equals `aRdData`. With direction 1, `bRd` and `aWr` are high and `aWrData` equals `bRdData`. The memory address is `{bank, address}`.
- R5: The peripheral address is the base plus an offset taken from a four-step pattern chosen by mode: modes 0, 2 and 6 use 0,0,0,0; modes 1 and 5 use 0,1,0,1; modes 3 and 7 use 0,0,1,1; mode 4 uses 0,1,2,3.
- R6: The pattern position advances by one for each byte and wraps after four bytes. It restarts at the first position when a channel finishes and when a burst starts.
- R7: Enabled channels are served in ascending channel order. Every byte of one channel is moved before any byte of the next channel.
- R8: After each byte, the 16-bit memory address is held if the fixed bit is set, drops by one if the count-down bit is set, and rises by one otherwise. It wraps within 16 bits and the bank never changes.
- R9: After each byte the count drops by one, and the channel finishes when the count reaches zero. A starting count of 0 moves 65536 bytes. A finished channel reads back count 0.
- R10: When a burst moves N bytes over C channels, `busy` is high for exactly START_CYCLES + N·BYTE_CYCLES + C·CHAN_CYCLES cycles. The first step comes START_CYCLES cycles after the enable write. Steps within a channel are BYTE_CYCLES apart, and a channel's first step comes CHAN_CYCLES later than that.
- R11: Writing an all-zero enable mask while idle starts nothing: `busy` stays low and no strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 7 | Register address {channel, offset} |
| regWr | input | 1 | Register write strobe |
| regWData | input | 8 | Register write data |
| regRData | output | 8 | Register read data (combinational) |
| openBus | input | 8 | Value returned for unmapped offsets |
| startWr | input | 1 | Enable mask write strobe |
| startMask | input | 8 | Channel enable mask |
| aAddr | output | 24 | Memory-side address {bank, address} |
| aRd | output | 1 | Memory-side read strobe |
| aWr | output | 1 | Memory-side write strobe |
| aRdData | input | 8 | Memory-side read data |
| aWrData | output | 8 | Memory-side write data |
| bAddr | output | 8 | Peripheral-side address |
| bRd | output | 1 | Peripheral-side read strobe |
| bWr | output | 1 | Peripheral-side write strobe |
| bRdData | input | 8 | Peripheral-side read data |
| bWrData | output | 8 | Peripheral-side write data |
| busy | output | 1 | High while a burst or its overhead is in progress |

## Verification
The first burst mixes a counting-up, memory-to-peripheral channel in mode 4 with a counting-down, peripheral-to-memory channel in mode 1. This separates the two directions and shows whether the pattern position restarts when the engine changes channel. A second burst covers the remaining modes, a fixed address and a memory address that crosses the 16-bit wrap. It uses seven channels, which tests priority order and the per-channel cycle penalty. A mode 4 channel is then run twice with a count of three, to show that the pattern position restarts between bursts. A copy of the block with one-cycle costs moves a count of zero, which shows the 65536-byte case.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NumCh = 8;
  localparam int ChW = $clog2(NumCh);

  // strobes from control to datapath
  typedef struct packed {
    logic           step;
    logic [ChW-1:0] chan;
    logic [1:0]     offIdx;
  } xfer_cmd_t;

  // peripheral address offset for a mode at a pattern position
  function automatic logic [1:0] bOffset(input logic [2:0] mode, input logic [1:0] idx);
    case (mode)
      3'd1, 3'd5: return {1'b0, idx[0]};
      3'd3, 3'd7: return {1'b0, idx[1]};
      3'd4:       return idx;
      default:    return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_seq.sv
module dma_seq import dma_pkg::*; #(
  parameter int BYTE_CYCLES  = 8,
  parameter int CHAN_CYCLES  = 8,
  parameter int START_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startWr,
  input  logic [NumCh-1:0] startMask,
  input  logic             selLast,
  output xfer_cmd_t        cmd,
  output logic             busy
);
  localparam int EndCost = BYTE_CYCLES - 1 + CHAN_CYCLES;
  localparam int TMax = (START_CYCLES > EndCost) ? START_CYCLES : EndCost;
  localparam int TW = (TMax < 1) ? 1 : $clog2(TMax + 1);

  logic [NumCh-1:0] activeMask;
  logic [TW-1:0]    timer;
  logic [1:0]       offIdx;
  logic [ChW-1:0]   chanSel;
  logic             done;

  always_comb begin
    chanSel = '0;
    for (int i = NumCh - 1; i >= 0; i--)
      if (activeMask[i]) chanSel = ChW'(i);
  end

  assign cmd.step   = (timer == '0) && (|activeMask);
  assign cmd.chan   = chanSel;
  assign cmd.offIdx = offIdx;
  assign done       = cmd.step && selLast;
  assign busy       = (timer != '0) || (|activeMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeMask <= '0;
      timer      <= '0;
      offIdx     <= '0;
    end else if (startWr) begin
      activeMask <= startMask;
      offIdx     <= '0;
      timer      <= (|startMask) ? TW'(START_CYCLES) : '0;
    end else if (cmd.step) begin
      offIdx <= done ? 2'd0 : offIdx + 2'd1;
      if (done) activeMask[chanSel] <= 1'b0;
      timer <= done ? TW'(EndCost) : TW'(BYTE_CYCLES - 1);
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  a_r6_offidx_restart: assert property (@(posedge clk) disable iff (!rstN)
    done && !startWr |=> offIdx == 2'd0);
  a_r7_mask_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    !startWr |=> (activeMask & ~$past(activeMask)) == '0);
  a_r7_one_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step && !startWr |=>
      $countones(activeMask) + ($past(done) ? 1 : 0) == $countones($past(activeMask)));
  a_r10_step_gap: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step && !startWr && (BYTE_CYCLES > 1) |=> !cmd.step);
  a_r11_zero_start: assert property (@(posedge clk) disable iff (!rstN)
    startWr && (startMask == '0) |=> !busy);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dma_pkg::*; (
  input  logic           clk,
  input  logic           rstN,
  input  logic [ChW+3:0] regAddr,
  input  logic           regWr,
  input  logic [7:0]     regWData,
  output logic [7:0]     regRData,
  input  logic [7:0]     openBus,
  input  xfer_cmd_t      cmd,
  output logic           selLast,
  output logic [23:0]    aAddr,
  output logic           aRd,
  output logic           aWr,
  input  logic [7:0]     aRdData,
  output logic [7:0]     aWrData,
  output logic [7:0]     bAddr,
  output logic           bRd,
  output logic           bWr,
  input  logic [7:0]     bRdData,
  output logic [7:0]     bWrData
);
  logic [7:0]  ctrl [NumCh];
  logic [7:0]  bBase[NumCh];
  logic [15:0] aAdr [NumCh];
  logic [7:0]  bank [NumCh];
  logic [15:0] cnt  [NumCh];
  logic [7:0]  indBk[NumCh];
  logic [15:0] tblAd[NumCh];
  logic [7:0]  lineC[NumCh];
  logic [7:0]  spare[NumCh];

  logic [ChW-1:0] rwCh;
  logic [3:0]     rwOff;
  assign rwCh  = regAddr[ChW+3:4];
  assign rwOff = regAddr[3:0];

  always_ff @(posedge clk) begin
    for (int c = 0; c < NumCh; c++) begin
      if (!rstN) begin
        ctrl[c]  <= 8'hFF;  bBase[c] <= 8'hFF;  aAdr[c]  <= 16'hFFFF;
        bank[c]  <= 8'hFF;  cnt[c]   <= 16'hFFFF; indBk[c] <= 8'hFF;
        tblAd[c] <= 16'hFFFF; lineC[c] <= 8'hFF; spare[c] <= 8'hFF;
      end else begin
        if (regWr && rwCh == ChW'(c)) begin
          case (rwOff)
            4'h0: ctrl[c]         <= regWData;
            4'h1: bBase[c]        <= regWData;
            4'h2: aAdr[c][7:0]    <= regWData;
            4'h3: aAdr[c][15:8]   <= regWData;
            4'h4: bank[c]         <= regWData;
            4'h5: cnt[c][7:0]     <= regWData;
            4'h6: cnt[c][15:8]    <= regWData;
            4'h7: indBk[c]        <= regWData;
            4'h8: tblAd[c][7:0]   <= regWData;
            4'h9: tblAd[c][15:8]  <= regWData;
            4'hA: lineC[c]        <= regWData;
            4'hB, 4'hF: spare[c]  <= regWData;
            default: ;
          endcase
        end
        if (cmd.step && cmd.chan == ChW'(c)) begin
          cnt[c] <= cnt[c] - 16'd1;
          if (!ctrl[c][3]) aAdr[c] <= ctrl[c][4] ? aAdr[c] - 16'd1 : aAdr[c] + 16'd1;
        end
      end
    end
  end

  always_comb begin
    case (rwOff)
      4'h0: regRData = ctrl[rwCh];
      4'h1: regRData = bBase[rwCh];
      4'h2: regRData = aAdr[rwCh][7:0];
      4'h3: regRData = aAdr[rwCh][15:8];
      4'h4: regRData = bank[rwCh];
      4'h5: regRData = cnt[rwCh][7:0];
      4'h6: regRData = cnt[rwCh][15:8];
      4'h7: regRData = indBk[rwCh];
      4'h8: regRData = tblAd[rwCh][7:0];
      4'h9: regRData = tblAd[rwCh][15:8];
      4'hA: regRData = lineC[rwCh];
      4'hB, 4'hF: regRData = spare[rwCh];
      default: regRData = openBus;
    endcase
  end

  logic toMem;
  assign toMem   = ctrl[cmd.chan][7];
  assign selLast = cnt[cmd.chan] == 16'd1;
  assign aAddr   = {bank[cmd.chan], aAdr[cmd.chan]};
  assign bAddr   = bBase[cmd.chan] + {6'd0, bOffset(ctrl[cmd.chan][2:0], cmd.offIdx)};
  assign aRd     = cmd.step && !toMem;
  assign bWr     = cmd.step && !toMem;
  assign bRd     = cmd.step && toMem;
  assign aWr     = cmd.step && toMem;
  assign bWrData = aRdData;
  assign aWrData = bRdData;

  // shadow of the previous step, used only by the checks below
  logic           chkStep;
  logic [ChW-1:0] chkCh;
  logic [15:0]    chkCnt, chkAdr;
  logic [7:0]     chkCtrl;
  always_ff @(posedge clk) begin
    chkStep <= rstN && cmd.step && !(regWr && rwCh == cmd.chan);
    chkCh   <= cmd.chan;
    chkCnt  <= cnt[cmd.chan];
    chkAdr  <= aAdr[cmd.chan];
    chkCtrl <= ctrl[cmd.chan];
  end

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rstN)
    chkStep |-> cnt[chkCh] == chkCnt - 16'd1);
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    chkStep |-> aAdr[chkCh] == (chkCtrl[3] ? chkAdr :
                                chkCtrl[4] ? chkAdr - 16'd1 : chkAdr + 16'd1));
  a_r4_strobe_pair: assert property (@(posedge clk) disable iff (!rstN)
    (aRd || aWr || bRd || bWr) |-> ($onehot({aRd, aWr}) && aRd == bWr && aWr == bRd));
endmodule

// File: rtl/dma_engine.sv
module dma_engine import dma_pkg::*; #(
  parameter int BYTE_CYCLES  = 8,
  parameter int CHAN_CYCLES  = 8,
  parameter int START_CYCLES = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [ChW+3:0] regAddr,
  input  logic           regWr,
  input  logic [7:0]     regWData,
  output logic [7:0]     regRData,
  input  logic [7:0]     openBus,
  input  logic           startWr,
  input  logic [NumCh-1:0] startMask,
  output logic [23:0]    aAddr,
  output logic           aRd,
  output logic           aWr,
  input  logic [7:0]     aRdData,
  output logic [7:0]     aWrData,
  output logic [7:0]     bAddr,
  output logic           bRd,
  output logic           bWr,
  input  logic [7:0]     bRdData,
  output logic [7:0]     bWrData,
  output logic           busy
);
  xfer_cmd_t cmd;
  logic      selLast;

  dma_seq #(
    .BYTE_CYCLES(BYTE_CYCLES), .CHAN_CYCLES(CHAN_CYCLES), .START_CYCLES(START_CYCLES)
  ) uSeq (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startMask(startMask),
    .selLast(selLast), .cmd(cmd), .busy(busy)
  );

  dma_chan_regs uRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWData(regWData),
    .regRData(regRData), .openBus(openBus), .cmd(cmd), .selLast(selLast),
    .aAddr(aAddr), .aRd(aRd), .aWr(aWr), .aRdData(aRdData), .aWrData(aWrData),
    .bAddr(bAddr), .bRd(bRd), .bWr(bWr), .bRdData(bRdData), .bWrData(bWrData)
  );
endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic [6:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [7:0] regWData = '0, openBus = 8'h3C;
  logic startWr = 1'b0, startWrF = 1'b0;
  logic [7:0] startMask = '0, startMaskF = '0;
  logic [7:0] regRData, fRegRData, aRdData, aWrData, bAddr, bRdData, bWrData;
  logic [23:0] aAddr;
  logic aRd, aWr, bRd, bWr, busy;
  logic [23:0] fAAddr;
  logic [7:0] fAWrData, fBAddr, fBWrData;
  logic fARd, fAWr, fBRd, fBWr, fBusy;

  // memory models
  function automatic logic [7:0] memA(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]};
  endfunction
  function automatic logic [7:0] memB(input logic [7:0] b);
    return {b[3:0], b[7:4]} ^ 8'hA5;
  endfunction
  assign aRdData = memA(aAddr);
  assign bRdData = memB(bAddr);

  dma_engine dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWData(regWData),
    .regRData(regRData), .openBus(openBus), .startWr(startWr), .startMask(startMask),
    .aAddr(aAddr), .aRd(aRd), .aWr(aWr), .aRdData(aRdData), .aWrData(aWrData),
    .bAddr(bAddr), .bRd(bRd), .bWr(bWr), .bRdData(bRdData), .bWrData(bWrData), .busy(busy));

  dma_engine #(.BYTE_CYCLES(1), .CHAN_CYCLES(0), .START_CYCLES(1)) dutFast (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regWData(regWData),
    .regRData(fRegRData), .openBus(openBus), .startWr(startWrF), .startMask(startMaskF),
    .aAddr(fAAddr), .aRd(fARd), .aWr(fAWr), .aRdData(8'h00), .aWrData(fAWrData),
    .bAddr(fBAddr), .bRd(fBRd), .bWr(fBWr), .bRdData(8'h00), .bWrData(fBWrData), .busy(fBusy));

  int checks = 0, failures = 0, cyc = 0, fSteps = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (fARd || fAWr) fSteps <= fSteps + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // scoreboard
  typedef struct { int c; logic [23:0] a; logic [7:0] b; logic toMem; logic [7:0] d; } item_t;
  item_t q[$];

  always @(negedge clk) begin
    if (rstN && (aRd || aWr || bRd || bWr)) begin
      if (q.size() == 0) begin
        check(1'b0, "R7 R9", "unexpected bus step", {aAddr, bAddr}, 0);
      end else begin
        item_t e;
        logic [7:0] d;
        e = q.pop_front();
        d = aWr ? aWrData : bWrData;
        check(cyc == e.c, "R10", "step cycle", cyc, e.c);
        check(aAddr == e.a, "R7 R8", "memory address", aAddr, e.a);
        check(bAddr == e.b, "R5 R6", "peripheral address", bAddr, e.b);
        check(aWr == e.toMem && bRd == e.toMem && aRd == !e.toMem && bWr == !e.toMem,
              "R4", "strobes", {aRd, aWr, bRd, bWr}, e.toMem);
        check(d == e.d, "R4", "data", d, e.d);
      end
    end
  end

  // model of channel settings
  logic [7:0]  mCtrl[8], mBase[8], mBank[8];
  logic [15:0] mAdr[8], mCnt[8];

  function automatic logic [1:0] patOff(input logic [2:0] mode, input int k);
    int p;
    p = k % 4;
    if (mode == 3'd4) return 2'(p);
    if (mode == 3'd1 || mode == 3'd5) return (p == 1 || p == 3) ? 2'd1 : 2'd0;
    if (mode == 3'd3 || mode == 3'd7) return (p >= 2) ? 2'd1 : 2'd0;
    return 2'd0;
  endfunction

  task automatic regWrite(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [6:0] a, output logic [7:0] d, output logic [7:0] fd);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRData; fd = fRegRData;
  endtask

  task automatic cfgChan(input int ch, input logic [7:0] ctl, input logic [7:0] base,
                         input logic [15:0] adr, input logic [7:0] bk, input logic [15:0] n);
    logic [6:0] h;
    h = {3'(ch), 4'h0};
    regWrite(h | 7'h0, ctl); regWrite(h | 7'h1, base);
    regWrite(h | 7'h2, adr[7:0]); regWrite(h | 7'h3, adr[15:8]);
    regWrite(h | 7'h4, bk);
    regWrite(h | 7'h5, n[7:0]); regWrite(h | 7'h6, n[15:8]);
    mCtrl[ch] = ctl; mBase[ch] = base; mAdr[ch] = adr; mBank[ch] = bk; mCnt[ch] = n;
  endtask

  task automatic runBurst(input logic [7:0] mask);
    int t, nBytes, nCh, busyCyc, base;
    logic [7:0] rd, fd;
    @(negedge clk);
    base = cyc;
    t = base + 17;
    nBytes = 0; nCh = 0;
    for (int ch = 0; ch < 8; ch++) begin
      if (mask[ch]) begin
        int n;
        n = (mCnt[ch] == 16'd0) ? 65536 : int'(mCnt[ch]);
        nCh++;
        for (int k = 0; k < n; k++) begin
          item_t e;
          e.c = t;
          e.a = {mBank[ch], mAdr[ch]};
          e.b = mBase[ch] + {6'd0, patOff(mCtrl[ch][2:0], k)};
          e.toMem = mCtrl[ch][7];
          e.d = e.toMem ? memB(e.b) : memA(e.a);
          q.push_back(e);
          if (!mCtrl[ch][3]) mAdr[ch] = mCtrl[ch][4] ? mAdr[ch] - 16'd1 : mAdr[ch] + 16'd1;
          t += 8;
          nBytes++;
        end
        mCnt[ch] = 16'd0;
        t += 8;
      end
    end
    startMask = mask; startWr = 1'b1;
    @(negedge clk);
    startWr = 1'b0;
    busyCyc = 0;
    while (busy && !finished) begin
      busyCyc++;
      @(negedge clk);
    end
    check(busyCyc == 16 + 8 * nBytes + 8 * nCh, "R10", "busy length", busyCyc,
          16 + 8 * nBytes + 8 * nCh);
    check(q.size() == 0, "R7 R9", "steps left over", q.size(), 0);
    for (int ch = 0; ch < 8; ch++) begin
      if (mask[ch]) begin
        logic [7:0] lo, hi;
        regRead({3'(ch), 4'h5}, lo, fd);
        regRead({3'(ch), 4'h6}, hi, fd);
        check({hi, lo} == 16'd0, "R9", "final count", {hi, lo}, 0);
        regRead({3'(ch), 4'h2}, lo, fd);
        regRead({3'(ch), 4'h3}, hi, fd);
        check({hi, lo} == mAdr[ch], "R8", "final address", {hi, lo}, mAdr[ch]);
        regRead({3'(ch), 4'h4}, rd, fd);
        check(rd == mBank[ch], "R8", "bank unchanged", rd, mBank[ch]);
      end
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    logic [7:0] rd, fd;
    int n, fBusyCyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2: reset state
    check(!busy && !aRd && !aWr && !bRd && !bWr, "R2", "idle after reset", busy, 0);
    regRead(7'h00, rd, fd); check(rd == 8'hFF, "R2", "ch0 control", rd, 8'hFF);
    regRead(7'h7A, rd, fd); check(rd == 8'hFF, "R2", "ch7 line counter", rd, 8'hFF);
    regRead(7'h35, rd, fd); check(rd == 8'hFF, "R2", "ch3 count low", rd, 8'hFF);
    regRead(7'h1B, rd, fd); check(rd == 8'hFF, "R2", "ch1 spare", rd, 8'hFF);
    // R1: register map
    regRead(7'h2C, rd, fd); check(rd == 8'h3C, "R1", "unmapped offset reads openBus", rd, 8'h3C);
    regRead(7'h6E, rd, fd); check(rd == 8'h3C, "R1", "offset 0xE reads openBus", rd, 8'h3C);
    regWrite(7'h3F, 8'h77);
    regRead(7'h3B, rd, fd); check(rd == 8'h77, "R1", "spare alias 0xF to 0xB", rd, 8'h77);
    regWrite(7'h69, 8'hA4);
    regRead(7'h69, rd, fd); check(rd == 8'hA4, "R1", "table address high", rd, 8'hA4);
    regRead(7'h68, rd, fd); check(rd == 8'hFF, "R1", "table address low untouched", rd, 8'hFF);
    // R3: spare control bits read back
    regWrite(7'h40, 8'h65);
    regRead(7'h40, rd, fd); check(rd == 8'h65, "R3", "control readback", rd, 8'h65);

    // R11: zero mask while idle
    @(negedge clk); startMask = 8'h00; startWr = 1'b1;
    @(negedge clk); startWr = 1'b0;
    n = 0;
    repeat (20) begin if (busy) n++; @(negedge clk); end
    check(n == 0, "R11", "busy after zero mask", n, 0);

    // burst 1: mode 4 up, to peripheral; mode 1 down, to memory
    cfgChan(2, 8'h04, 8'h10, 16'h2000, 8'h7E, 16'd6);
    cfgChan(5, 8'h91, 8'h20, 16'h0101, 8'h01, 16'd3);
    runBurst(8'h24);

    // burst 2: remaining modes, fixed address, 16-bit wrap, seven channels
    cfgChan(0, 8'h0B, 8'h40, 16'h4444, 8'h12, 16'd5);
    cfgChan(1, 8'h87, 8'h50, 16'hFFFE, 8'h33, 16'd4);
    cfgChan(3, 8'h00, 8'h60, 16'h1234, 8'h05, 16'd2);
    cfgChan(4, 8'h12, 8'h70, 16'h0001, 8'h06, 16'd3);
    cfgChan(5, 8'h01, 8'h80, 16'h8000, 8'h07, 16'd1);
    cfgChan(6, 8'h86, 8'h90, 16'hABCD, 8'h08, 16'd2);
    cfgChan(7, 8'h05, 8'hA0, 16'h00FF, 8'h09, 16'd3);
    runBurst(8'hFB);

    // R6: pattern restarts for a new burst on the same channel
    cfgChan(2, 8'h04, 8'hC0, 16'h3000, 8'h02, 16'd3);
    runBurst(8'h04);
    cfgChan(2, 8'h04, 8'hC0, 16'h3000, 8'h02, 16'd3);
    runBurst(8'h04);

    // R9: count of zero moves 65536 bytes (one-cycle-cost instance)
    cfgChan(4, 8'h00, 8'h00, 16'h1000, 8'h00, 16'd0);
    @(negedge clk);
    fSteps = 0;
    startMaskF = 8'h10; startWrF = 1'b1;
    @(negedge clk); startWrF = 1'b0;
    fBusyCyc = 0;
    while (fBusy && !finished) begin fBusyCyc++; @(negedge clk); end
    check(fSteps == 65536, "R9", "bytes moved for count 0", fSteps, 65536);
    check(fBusyCyc == 1 + 65536, "R10", "busy length, one-cycle costs", fBusyCyc, 65537);
    regRead(7'h42, rd, fd); check(fd == 8'h00, "R8", "wrapped address low", fd, 8'h00);
    regRead(7'h43, rd, fd); check(fd == 8'h10, "R8", "wrapped address high", fd, 8'h10);
    regRead(7'h46, rd, fd); check(fd == 8'h00, "R9", "count after 65536 bytes", fd, 8'h00);

    finishRun();
  end
endmodule